// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

The block is a register-mapped controller for a row of general-purpose pins, 64 or 96 of them, organised in banks of 32. Software reads the synchronized pin levels and sets each pin's direction. It changes output values through write-one set and clear words, so it never has to read, modify and write the output state. It arms rising-edge and falling-edge capture for each pin separately, and it selects one of four alternate functions per pin through 2-bit fields.

Every pin input passes through a two-stage synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier. An armed edge sets a sticky status bit. Writing a one to that bit clears it. All status bits are ORed into one interrupt line. Software clears a status bit before it services the pin. If an edge arrives in the same clock as that clear, the edge wins, so no event is lost.

Register word address = group × banks + bank. The groups, in order, are: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status, 7 alternate function. The alternate-function group holds twice as many words as there are banks. The block has no state machine: all control is direct register decode.

Top module: `gpio_banked`

## Requirements
- R1: While reset is low and on release, pin_out, pin_oe, alt_sel, every edge-status bit and irq are all zero.
- R2: Word address g×NB+b (NB = NUM_PINS/32) selects group g for bank b. Pin n lives at bank n/32, bit n%32. Addresses with no register read as zero.
- R3: A write to the output-set word of bank b drives pin_out high for every 1 bit of the data. Bits written 0 keep their value. A read of the set or clear word returns the output latch.
- R4: A write to the output-clear word of bank b drives pin_out low for every 1 bit of the data. Bits written 0 keep their value.
- R5: pin_oe equals the direction register: 1 means output, 0 means input. pin_oe changes only on a write to a direction word.
- R6: A level word returns the synchronized pin inputs, whatever the direction. A change on pin_in becomes readable after the second rising clock edge.
- R7: With its rising-enable bit set, a 0-to-1 input change sets the pin's status bit at the third clock edge after the change. With the enable clear, nothing is recorded.
- R8: With its falling-enable bit set, a 1-to-0 input change sets the pin's status bit in the same way. A rising-only pin records no falling edge.
- R9: Writing a 1 to a status bit clears it. Bits written 0 stay unchanged.
- R10: When a new edge and a clearing write hit the same status bit in the same clock, the bit stays set.
- R11: irq is high exactly when at least one status bit in any bank is set.
- R12: Pin n's alternate-function field is held in word 7×NB + n/16, at bits (n%16)×2+1 to (n%16)×2. It drives alt_sel[2n+1:2n].
- R13: Writes to a level word have no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW = clog2(9×NUM_PINS/32) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Output values |
| pin_oe | output | NUM_PINS | Output enables |
| alt_sel | output | 2×NUM_PINS | Alternate-function selects, 2 bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The capture of a new edge and a software clear of the same status bit can fall in one clock. The bench arms a pin that already has its status bit set. It then changes the pin input and times the clearing write so that the write lands on the exact edge where the synchronizer delivers the new transition. The status bit must read as 1 afterwards, and irq must stay high. A following clear with no edge must leave the bit at 0, which shows that the first outcome came from the edge taking priority.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        GRP_LEVEL = 4'd0,
        GRP_DIR   = 4'd1,
        GRP_SET   = 4'd2,
        GRP_CLR   = 4'd3,
        GRP_RISE  = 4'd4,
        GRP_FALL  = 4'd5,
        GRP_STAT  = 4'd6,
        GRP_ALT   = 4'd7
    } gpio_grp_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] status_q;

    // edges seen this cycle, filtered by the enables
    assign hit = (rise_en & level & ~prev_q) | (fall_en & ~level & prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= level;
            // a fresh edge overrides a same-cycle clear
            status_q <= (status_q & ~clr_mask) | hit;
        end
    end

    assign status = status_q;
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked #(
    parameter  int NUM_PINS = 64,
    localparam int NB       = NUM_PINS / 32,
    localparam int NWORDS   = 9 * NB,
    localparam int AW       = $clog2(NWORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [AW-1:0]         reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] alt_sel,
    output logic                  irq
);
    import gpio_pkg::*;

    localparam int NALT = 2 * NB;

    logic [NUM_PINS-1:0]   lvl_sync;
    logic [NUM_PINS-1:0]   dir_all;
    logic [NUM_PINS-1:0]   out_all;
    logic [NUM_PINS-1:0]   rise_all;
    logic [NUM_PINS-1:0]   fall_all;
    logic [NUM_PINS-1:0]   edge_status;
    logic [NUM_PINS-1:0]   edge_hit;
    logic [2*NUM_PINS-1:0] alt_all;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl_sync)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [AW-1:0] A_DIR  = AW'(int'(GRP_DIR)  * NB + b);
        localparam logic [AW-1:0] A_SET  = AW'(int'(GRP_SET)  * NB + b);
        localparam logic [AW-1:0] A_CLR  = AW'(int'(GRP_CLR)  * NB + b);
        localparam logic [AW-1:0] A_RISE = AW'(int'(GRP_RISE) * NB + b);
        localparam logic [AW-1:0] A_FALL = AW'(int'(GRP_FALL) * NB + b);
        localparam logic [AW-1:0] A_STAT = AW'(int'(GRP_STAT) * NB + b);

        logic [WORD_W-1:0] dir_q;
        logic [WORD_W-1:0] out_q;
        logic [WORD_W-1:0] rise_q;
        logic [WORD_W-1:0] fall_q;
        logic [WORD_W-1:0] clr_mask;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dir_q  <= '0;
                out_q  <= '0;
                rise_q <= '0;
                fall_q <= '0;
            end else if (reg_we) begin
                if (reg_addr == A_DIR)  dir_q  <= reg_wdata;
                if (reg_addr == A_SET)  out_q  <= out_q | reg_wdata;
                if (reg_addr == A_CLR)  out_q  <= out_q & ~reg_wdata;
                if (reg_addr == A_RISE) rise_q <= reg_wdata;
                if (reg_addr == A_FALL) fall_q <= reg_wdata;
            end
        end

        assign clr_mask = (reg_we && reg_addr == A_STAT) ? reg_wdata : '0;

        gpio_edge_bank #(.W(WORD_W)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (lvl_sync[b*WORD_W +: WORD_W]),
            .rise_en  (rise_q),
            .fall_en  (fall_q),
            .clr_mask (clr_mask),
            .status   (edge_status[b*WORD_W +: WORD_W]),
            .hit      (edge_hit[b*WORD_W +: WORD_W])
        );

        assign dir_all[b*WORD_W +: WORD_W]  = dir_q;
        assign out_all[b*WORD_W +: WORD_W]  = out_q;
        assign rise_all[b*WORD_W +: WORD_W] = rise_q;
        assign fall_all[b*WORD_W +: WORD_W] = fall_q;
    end

    for (genvar k = 0; k < NALT; k++) begin : g_alt
        localparam logic [AW-1:0] A_ALT = AW'(int'(GRP_ALT) * NB + k);
        logic [WORD_W-1:0] alt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alt_q <= '0;
            end else if (reg_we && reg_addr == A_ALT) begin
                alt_q <= reg_wdata;
            end
        end

        assign alt_all[k*WORD_W +: WORD_W] = alt_q;
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == AW'(int'(GRP_LEVEL) * NB + b)) reg_rdata = lvl_sync[b*WORD_W +: WORD_W];
            if (reg_addr == AW'(int'(GRP_DIR)   * NB + b)) reg_rdata = dir_all[b*WORD_W +: WORD_W];
            if (reg_addr == AW'(int'(GRP_SET)   * NB + b)) reg_rdata = out_all[b*WORD_W +: WORD_W];
            if (reg_addr == AW'(int'(GRP_CLR)   * NB + b)) reg_rdata = out_all[b*WORD_W +: WORD_W];
            if (reg_addr == AW'(int'(GRP_RISE)  * NB + b)) reg_rdata = rise_all[b*WORD_W +: WORD_W];
            if (reg_addr == AW'(int'(GRP_FALL)  * NB + b)) reg_rdata = fall_all[b*WORD_W +: WORD_W];
            if (reg_addr == AW'(int'(GRP_STAT)  * NB + b)) reg_rdata = edge_status[b*WORD_W +: WORD_W];
        end
        for (int k = 0; k < NALT; k++) begin
            if (reg_addr == AW'(int'(GRP_ALT) * NB + k)) reg_rdata = alt_all[k*WORD_W +: WORD_W];
        end
    end

    assign pin_out = out_all;
    assign pin_oe  = dir_all;
    assign alt_sel = alt_all;
    assign irq     = |edge_status;
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
    parameter  int NUM_PINS = 64,
    localparam int NB       = NUM_PINS / 32,
    localparam int AW       = $clog2(9 * NB)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [AW-1:0]         reg_addr,
    input logic [31:0]           reg_wdata,
    input logic [NUM_PINS-1:0]   pin_out,
    input logic [NUM_PINS-1:0]   pin_oe,
    input logic [2*NUM_PINS-1:0] alt_sel,
    input logic                  irq,
    input logic [NUM_PINS-1:0]   edge_status,
    input logic [NUM_PINS-1:0]   edge_hit
);
    import gpio_pkg::*;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && alt_sel == '0 && edge_status == '0 && !irq));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == AW'(int'(GRP_SET) * NB + b))
            |=> ((pin_out[b*32 +: 32] & $past(reg_wdata)) == $past(reg_wdata)));

        a_r4_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == AW'(int'(GRP_CLR) * NB + b))
            |=> ((pin_out[b*32 +: 32] & $past(reg_wdata)) == '0));
    end

    a_r5_oe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(pin_oe));

    a_r9_no_spurious_status: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((edge_status & ~$past(edge_status) & ~$past(edge_hit)) == '0));

    a_r10_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((edge_status & $past(edge_hit)) == $past(edge_hit)));

    a_r11_irq_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> irq);
endmodule

bind gpio_banked gpio_banked_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .alt_sel     (alt_sel),
    .irq         (irq),
    .edge_status (edge_status),
    .edge_hit    (edge_hit)
);

// File: tb/gpio_banked_test.sv
module gpio_banked_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PINS   = 64;
    localparam int NB         = NUM_PINS / 32;
    localparam int AW         = $clog2(9 * NB);
    localparam int G_LEVEL = 0, G_DIR = 1, G_SET = 2, G_CLR = 3;
    localparam int G_RISE = 4, G_FALL = 5, G_STAT = 6, G_ALT = 7;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  reg_we = 1'b0;
    logic [AW-1:0]         reg_addr = '0;
    logic [31:0]           reg_wdata = '0;
    logic [31:0]           reg_rdata;
    logic [NUM_PINS-1:0]   pin_in = '0;
    logic [NUM_PINS-1:0]   pin_out;
    logic [NUM_PINS-1:0]   pin_oe;
    logic [2*NUM_PINS-1:0] alt_sel;
    logic                  irq;

    int checks = 0;
    int fails  = 0;
    logic [NUM_PINS-1:0]   out_m;
    logic [2*NUM_PINS-1:0] alt_m;
    logic [31:0]           rd;

    gpio_banked #(.NUM_PINS(NUM_PINS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt_sel   (alt_sel),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int adr(input int grp, input int idx);
        return grp * NB + idx;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rdw(input int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        // R1: state held in reset
        chk("R1 pin_out", pin_out, '0);
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 alt_sel", alt_sel, '0);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        wait_cyc(1);
        for (int b = 0; b < NB; b++) begin
            rdw(adr(G_STAT, b), rd);
            chk("R1 status", rd, 32'h0);
        end

        // R5 / R2: direction per bank
        for (int b = 0; b < NB; b++) wr(adr(G_DIR, b), 32'hA5C3_0000 | b);
        for (int b = 0; b < NB; b++) begin
            chk("R5 pin_oe slice", pin_oe[b*32 +: 32], 32'hA5C3_0000 | b);
            rdw(adr(G_DIR, b), rd);
            chk("R2 dir readback", rd, 32'hA5C3_0000 | b);
        end
        rdw(9 * NB, rd);
        chk("R2 unmapped reads zero", rd, 32'h0);

        // R3: per-pin set sweep
        out_m = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            wr(adr(G_SET, n / 32), 32'h1 << (n % 32));
            out_m[n] = 1'b1;
            chk("R3 set pin", pin_out, out_m);
        end
        wr(adr(G_SET, 0), 32'h0);
        chk("R3 zero set no effect", pin_out, out_m);
        // R4: clear every third pin
        for (int n = 0; n < NUM_PINS; n += 3) begin
            wr(adr(G_CLR, n / 32), 32'h1 << (n % 32));
            out_m[n] = 1'b0;
            chk("R4 clear pin", pin_out, out_m);
        end
        wr(adr(G_CLR, 1), 32'h0);
        chk("R4 zero clear no effect", pin_out, out_m);
        for (int b = 0; b < NB; b++) begin
            rdw(adr(G_CLR, b), rd);
            chk("R3 clear word reads latch", rd, out_m[b*32 +: 32]);
        end

        // R6: level reads with all pins as outputs, then as inputs
        wr(adr(G_DIR, 0), 32'hFFFF_FFFF);
        for (int p = 0; p < 4; p++) begin
            logic [NUM_PINS-1:0] pat;
            pat = {NUM_PINS/16{16'h1234 * (p + 3)}} ^ (64'h1 << (p * 13));
            pin_in = pat;
            wait_cyc(2);
            for (int b = 0; b < NB; b++) begin
                rdw(adr(G_LEVEL, b), rd);
                chk("R6 level word", rd, pat[b*32 +: 32]);
            end
        end
        // R13: writing a level word changes nothing
        wr(adr(G_LEVEL, 0), 32'hFFFF_FFFF);
        rdw(adr(G_LEVEL, 0), rd);
        chk("R13 level unchanged", rd, pin_in[31:0]);
        chk("R13 pin_out unchanged", pin_out, out_m);

        pin_in = '0;
        wait_cyc(4);
        chk("R7 no capture when disarmed", irq, 1'b0);

        // R7 / R9 / R11: rising sweep, falling disarmed
        for (int b = 0; b < NB; b++) wr(adr(G_RISE, b), 32'hFFFF_FFFF);
        for (int n = 0; n < NUM_PINS; n++) begin
            pin_in = '0; pin_in[n] = 1'b1;
            wait_cyc(2);
            chk("R7 not before third edge", irq, 1'b0);
            wait_cyc(2);
            rdw(adr(G_STAT, n / 32), rd);
            chk("R7 rising captured", rd, 32'h1 << (n % 32));
            chk("R11 irq raised", irq, 1'b1);
            pin_in[n] = 1'b0;
            wait_cyc(4);
            rdw(adr(G_STAT, n / 32), rd);
            chk("R8 falling ignored when disarmed", rd, 32'h1 << (n % 32));
            wr(adr(G_STAT, n / 32), 32'h0);
            rdw(adr(G_STAT, n / 32), rd);
            chk("R9 zero write keeps status", rd, 32'h1 << (n % 32));
            wr(adr(G_STAT, n / 32), 32'h1 << (n % 32));
            rdw(adr(G_STAT, n / 32), rd);
            chk("R9 one clears status", rd, 32'h0);
            chk("R11 irq dropped", irq, 1'b0);
        end

        // R8: falling capture on bank 1 pin 40
        wr(adr(G_RISE, 1), 32'h0);
        wr(adr(G_FALL, 1), 32'h0000_0100);
        pin_in[40] = 1'b1;
        wait_cyc(4);
        chk("R8 rise not recorded", irq, 1'b0);
        pin_in[40] = 1'b0;
        wait_cyc(4);
        rdw(adr(G_STAT, 1), rd);
        chk("R8 falling captured", rd, 32'h0000_0100);
        wr(adr(G_STAT, 1), 32'h0000_0100);

        // R10: edge and clear in the same cycle on pin 3
        wr(adr(G_FALL, 0), 32'h0000_0008);
        pin_in[3] = 1'b1;
        wait_cyc(4);
        rdw(adr(G_STAT, 0), rd);
        chk("R10 setup status", rd, 32'h0000_0008);
        pin_in[3] = 1'b0;
        @(negedge clk);
        wr(adr(G_STAT, 0), 32'h0000_0008);
        rdw(adr(G_STAT, 0), rd);
        chk("R10 edge wins over clear", rd, 32'h0000_0008);
        chk("R10 irq held", irq, 1'b1);
        wr(adr(G_STAT, 0), 32'h0000_0008);
        rdw(adr(G_STAT, 0), rd);
        chk("R10 later clear works", rd, 32'h0);

        // R12: alternate-function words and per-pin fields
        alt_m = '0;
        for (int k = 0; k < 2 * NB; k++) begin
            logic [31:0] w;
            w = 32'h1B2D_E4C6 ^ (32'h9E37_79B9 * (k + 1));
            wr(adr(G_ALT, k), w);
            alt_m[k*32 +: 32] = w;
        end
        for (int n = 0; n < NUM_PINS; n++) begin
            logic [31:0] w;
            rdw(adr(G_ALT, n / 16), w);
            chk("R12 pin field", alt_sel[2*n +: 2], (w >> ((n % 16) * 2)) & 32'h3);
        end
        chk("R12 alt_sel vector", alt_sel, alt_m);

        finish_run();
    end
endmodule